// File: doc/BRIEF.md
# LIN Frame Request and Response-Timeout Controller

This block turns a byte-serial command stream written by software into one LIN frame request. It also watches the slave's reply when the frame reads data. The first byte carries the frame identifier. The second carries the direction and the data length. The third carries the top four bits of a twelve-bit response timeout. The meaning of the fourth byte depends on direction. On a receive frame it supplies the low eight timeout bits. On a transmit frame it is already the first payload byte, and every later byte is payload in order. Once the header is complete, the block offers a frame descriptor to the bit-level transmitter. On transmit frames it then forwards the payload bytes through a one-entry holding register.

On a receive frame the block waits for the strobe that marks the start of the break character. It then loads its bit-time counter with the timeout and decrements it on each bit-time tick from the baud generator. Counting stops once the expected response bytes have arrived: the data bytes plus one checksum byte. If the count runs out first, a sticky no-response error is raised, the frame is dropped and the sequencer returns to waiting for a new first byte. Each received byte is held in a read register. A ready flag gates that register, and an overrun flag records a byte that arrived before the previous one was read.

The command port and the payload port are valid/ready streams. A command byte is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` drops in three cases:
- while a finished header waits for `hdr_ready`;
- while a receive frame waits for its break or its response;
- while the payload register is full and `txd_ready` is low.

`hdr_valid` and `txd_valid`, once raised, hold with stable contents until the matching ready is seen. The receive byte input cannot be stalled. Losing a byte shows up as an overrun instead.

Top module: `lin_frame_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `hdr_valid`, `txd_valid`, `rx_ready`, `noresp_err` and `overrun` are 0.
- R2: The command bytes are decoded as follows; only bits 7:0 of `cmd_data` are used.
  - Byte 1, bits 5:0, give `hdr_id`.
  - Byte 2, bit 7, gives `hdr_tx` (1 = transmit, 0 = receive), and byte 2, bits 3:0, give `hdr_len`.
  - `hdr_valid` rises after byte 3 on a transmit frame and after byte 4 on a receive frame.
- R3: On a transmit frame, the value of byte 3 is ignored. Byte 4 and the later bytes appear on `txd_data` in write order. Exactly `hdr_len` bytes are forwarded, and then the sequencer accepts a new byte 1. A transmit frame with length 0 returns to byte 1 once its header is accepted.
- R4: On a receive frame, the timeout is T = {byte3[3:0], byte4[7:0]} bit times. The counter is loaded on the `brk_start` strobe. `noresp_err` stays 0 through T−1 `bit_tick` strobes and is 1 in the cycle after the T-th strobe.
- R5: When the no-response error is raised, the frame is aborted and `cmd_ready` is 1 in the same cycle.
- R6: If `hdr_len`+1 bytes arrive on `rxb_valid` before the timeout expires, counting stops, no error is raised and the sequencer returns to byte 1.
- R7: A transmit frame never raises `noresp_err`, however many ticks and breaks follow.
- R8: `noresp_err` stays set until a cycle with `err_clr[0]` = 1, which clears it.
- R9: Each received byte sets `rx_ready`. `rx_data` shows the byte while `rx_ready` is 1 and reads 0 otherwise. An `rx_rd` strobe without a new byte clears `rx_ready`.
- R10: A byte that arrives while `rx_ready` is 1 and no `rx_rd` is given sets `overrun` and replaces the held byte. `err_clr[1]` = 1 clears `overrun`.
- R11: The command port applies back-pressure. `cmd_ready` is 0 while `hdr_valid` waits for `hdr_ready`, and 0 while the payload register is full and `txd_ready` is 0. `txd_valid` and `txd_data` stay stable until accepted.
- R12: A receive frame whose timeout is 0 never raises `noresp_err`. It ends only when its `hdr_len`+1 response bytes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte can be taken |
| cmd_data | input | CMD_W (16) | Command write; bits 7:0 meaningful |
| hdr_valid | output | 1 | Frame descriptor offered |
| hdr_ready | input | 1 | Transmitter takes the descriptor |
| hdr_id | output | ID_W (6) | Frame identifier |
| hdr_tx | output | 1 | 1 = transmit frame, 0 = receive frame |
| hdr_len | output | LEN_W (4) | Number of data bytes |
| txd_valid | output | 1 | Payload byte offered |
| txd_ready | input | 1 | Transmitter takes the payload byte |
| txd_data | output | 8 | Payload byte |
| brk_start | input | 1 | Strobe: break character starts going out |
| bit_tick | input | 1 | Strobe: one bit time elapsed |
| rxb_valid | input | 1 | Strobe: byte received from the bus |
| rxb_data | input | 8 | Received byte |
| rx_ready | output | 1 | Read register holds an unread byte |
| rx_rd | input | 1 | Strobe: software reads the register |
| rx_data | output | 8 | Read register, 0 while not ready |
| noresp_err | output | 1 | Sticky no-response error |
| overrun | output | 1 | Sticky receive overrun |
| err_clr | input | 2 | Write-one-to-clear: bit 0 error, bit 1 overrun |

## Verification
Several properties are checked on every cycle:
- the no-response error only clears on an explicit clear;
- the bit-time counter never counts up while a response window is open;
- raising the error always leaves the command port ready;
- an unread register hit by a new byte always flags overrun, and a plain read always drops the ready flag;
- a stalled descriptor or payload byte holds its contents.

Some behaviour is shown only by the bench's sweeps over every length from 0 to 8:
- the exact tick on which the error rises for the recommended timeout (10×N+45)×1.4;
- a timeout whose upper bits come from the third byte;
- that the fourth byte switches meaning with direction;
- the ordering of payload bytes;
- that transmit frames and zero-timeout frames never time out.

// File: rtl/lin_fc_pkg.sv
package lin_fc_pkg;
  typedef enum logic [2:0] {
    S_ID   = 3'd0,
    S_CTL  = 3'd1,
    S_TOH  = 3'd2,
    S_TOL  = 3'd3,
    S_HDR  = 3'd4,
    S_DATA = 3'd5,
    S_BRK  = 3'd6,
    S_RESP = 3'd7
  } seq_state_t;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned DIR_BIT = 7;
endpackage

// File: rtl/lin_cmd_seq.sv
module lin_cmd_seq
  import lin_fc_pkg::*;
#(
  parameter int unsigned ID_W  = 6,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned TO_W  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [BYTE_W-1:0]   cmd_byte,
  output logic                hdr_valid,
  input  logic                hdr_ready,
  output logic [ID_W-1:0]     hdr_id,
  output logic                hdr_tx,
  output logic [LEN_W-1:0]    hdr_len,
  output logic                txd_valid,
  input  logic                txd_ready,
  output logic [BYTE_W-1:0]   txd_data,
  input  logic                brk_start,
  input  logic                resp_done,
  input  logic                resp_expire,
  output logic                tmr_load,
  output logic [TO_W-1:0]     frm_to,
  output logic [LEN_W-1:0]    frm_len
);
  localparam int unsigned TOH_W = TO_W - BYTE_W;

  seq_state_t          state_q, state_d;
  logic [ID_W-1:0]     id_q;
  logic                tx_q;
  logic [LEN_W-1:0]    len_q;
  logic [TOH_W-1:0]    toh_q;
  logic [BYTE_W-1:0]   tol_q;
  logic [LEN_W-1:0]    dcnt_q;
  logic                txv_q;
  logic [BYTE_W-1:0]   txb_q;
  logic                acc;
  logic                last_data;

  always_comb begin
    unique case (state_q)
      S_ID, S_CTL, S_TOH, S_TOL: cmd_ready = 1'b1;
      S_DATA:                    cmd_ready = !txv_q || txd_ready;
      default:                   cmd_ready = 1'b0;
    endcase
  end

  assign acc       = cmd_valid && cmd_ready;
  assign last_data = (dcnt_q + 1'b1) == len_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_ID:   if (acc) state_d = S_CTL;
      S_CTL:  if (acc) state_d = S_TOH;
      S_TOH:  if (acc) state_d = tx_q ? S_HDR : S_TOL;
      S_TOL:  if (acc) state_d = S_HDR;
      S_HDR:  if (hdr_ready) begin
                if (!tx_q)              state_d = S_BRK;
                else if (len_q == '0)   state_d = S_ID;
                else                    state_d = S_DATA;
              end
      S_DATA: if (acc && last_data) state_d = S_ID;
      S_BRK:  if (brk_start) state_d = S_RESP;
      S_RESP: if (resp_done || resp_expire) state_d = S_ID;
      default: state_d = S_ID;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_ID;
      id_q    <= '0;
      tx_q    <= 1'b0;
      len_q   <= '0;
      toh_q   <= '0;
      tol_q   <= '0;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (acc) begin
        unique case (state_q)
          S_ID: begin
            id_q  <= cmd_byte[ID_W-1:0];
            toh_q <= '0;
            tol_q <= '0;
          end
          S_CTL: begin
            tx_q  <= cmd_byte[DIR_BIT];
            len_q <= cmd_byte[LEN_W-1:0];
          end
          S_TOH:  toh_q <= tx_q ? '0 : cmd_byte[TOH_W-1:0];
          S_TOL:  tol_q <= cmd_byte;
          S_DATA: dcnt_q <= dcnt_q + 1'b1;
          default: ;
        endcase
      end
      if (state_q == S_HDR) dcnt_q <= '0;
    end
  end

  // one-entry payload holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txv_q <= 1'b0;
      txb_q <= '0;
    end else begin
      if (txv_q && txd_ready) txv_q <= 1'b0;
      if (state_q == S_DATA && acc) begin
        txv_q <= 1'b1;
        txb_q <= cmd_byte;
      end
    end
  end

  assign hdr_valid = (state_q == S_HDR);
  assign hdr_id    = id_q;
  assign hdr_tx    = tx_q;
  assign hdr_len   = len_q;
  assign txd_valid = txv_q;
  assign txd_data  = txb_q;
  assign tmr_load  = (state_q == S_BRK) && brk_start;
  assign frm_to    = {toh_q, tol_q};
  assign frm_len   = len_q;

  assert_txd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    txd_valid && !txd_ready |=> txd_valid && $stable(txd_data));

  assert_hdr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_id) && $stable(hdr_len));
endmodule

// File: rtl/lin_resp_timer.sv
module lin_resp_timer #(
  parameter int unsigned TO_W  = 12,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TO_W-1:0]  to_val,
  input  logic [LEN_W-1:0] len_val,
  input  logic             bit_tick,
  input  logic             rxb_valid,
  input  logic             err_clr,
  output logic             done,
  output logic             expire,
  output logic             noresp_err
);
  localparam int unsigned GOT_W = LEN_W + 1;

  logic [TO_W-1:0]  cnt_q;
  logic [GOT_W-1:0] got_q;
  logic [GOT_W-1:0] need_q;
  logic             en_q;
  logic             act_q;
  logic             err_q;

  assign done   = act_q && rxb_valid && ((got_q + 1'b1) == need_q);
  assign expire = act_q && en_q && bit_tick && (cnt_q == TO_W'(1)) && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      got_q  <= '0;
      need_q <= '0;
      en_q   <= 1'b0;
      act_q  <= 1'b0;
    end else if (load) begin
      cnt_q  <= to_val;
      got_q  <= '0;
      need_q <= {1'b0, len_val} + 1'b1;
      en_q   <= (to_val != '0);
      act_q  <= 1'b1;
    end else if (act_q) begin
      if (done || expire) begin
        act_q <= 1'b0;
      end else begin
        if (rxb_valid)       got_q <= got_q + 1'b1;
        if (bit_tick && en_q) cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (expire)  err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  assign noresp_err = err_q;

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    noresp_err && !err_clr |=> noresp_err);

  assert_cnt_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !load |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/lin_rx_hold.sv
module lin_rx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxb_valid,
  input  logic [DW-1:0] rxb_data,
  input  logic          rx_rd,
  input  logic          ovr_clr,
  output logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          overrun
);
  logic          rdy_q;
  logic [DW-1:0] dat_q;
  logic          ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      dat_q <= '0;
    end else if (rxb_valid) begin
      rdy_q <= 1'b1;
      dat_q <= rxb_data;
    end else if (rx_rd) begin
      rdy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ovr_q <= 1'b0;
    else if (rxb_valid && rdy_q && !rx_rd) ovr_q <= 1'b1;
    else if (ovr_clr)                      ovr_q <= 1'b0;
  end

  assign rx_ready = rdy_q;
  assign rx_data  = rdy_q ? dat_q : '0;
  assign overrun  = ovr_q;

  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_valid && rx_ready && !rx_rd |=> overrun && rx_ready);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !rxb_valid |=> !rx_ready);
endmodule

// File: rtl/lin_frame_ctrl.sv
module lin_frame_ctrl
  import lin_fc_pkg::*;
#(
  parameter int unsigned ID_W  = 6,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned TO_W  = 12,
  parameter int unsigned CMD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              hdr_valid,
  input  logic              hdr_ready,
  output logic [ID_W-1:0]   hdr_id,
  output logic              hdr_tx,
  output logic [LEN_W-1:0]  hdr_len,
  output logic              txd_valid,
  input  logic              txd_ready,
  output logic [7:0]        txd_data,
  input  logic              brk_start,
  input  logic              bit_tick,
  input  logic              rxb_valid,
  input  logic [7:0]        rxb_data,
  output logic              rx_ready,
  input  logic              rx_rd,
  output logic [7:0]        rx_data,
  output logic              noresp_err,
  output logic              overrun,
  input  logic [1:0]        err_clr
);
  logic             unused_hi;
  logic             tmr_load;
  logic [TO_W-1:0]  frm_to;
  logic [LEN_W-1:0] frm_len;
  logic             resp_done;
  logic             resp_expire;

  assign unused_hi = ^cmd_data[CMD_W-1:BYTE_W];

  lin_cmd_seq #(.ID_W(ID_W), .LEN_W(LEN_W), .TO_W(TO_W)) u_seq (
    .clk, .rst_n,
    .cmd_valid, .cmd_ready, .cmd_byte(cmd_data[BYTE_W-1:0]),
    .hdr_valid, .hdr_ready, .hdr_id, .hdr_tx, .hdr_len,
    .txd_valid, .txd_ready, .txd_data,
    .brk_start, .resp_done, .resp_expire,
    .tmr_load, .frm_to, .frm_len
  );

  lin_resp_timer #(.TO_W(TO_W), .LEN_W(LEN_W)) u_tmr (
    .clk, .rst_n,
    .load(tmr_load), .to_val(frm_to), .len_val(frm_len),
    .bit_tick, .rxb_valid, .err_clr(err_clr[0]),
    .done(resp_done), .expire(resp_expire), .noresp_err
  );

  lin_rx_hold #(.DW(BYTE_W)) u_rx (
    .clk, .rst_n,
    .rxb_valid, .rxb_data, .rx_rd, .ovr_clr(err_clr[1]),
    .rx_ready, .rx_data, .overrun
  );

  assert_abort_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_expire |=> noresp_err && cmd_ready);
endmodule

// File: tb/lin_frame_ctrl_bench.sv
module lin_frame_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = '0;
  logic        hdr_valid;
  logic        hdr_ready = 1'b1;
  logic [5:0]  hdr_id;
  logic        hdr_tx;
  logic [3:0]  hdr_len;
  logic        txd_valid;
  logic        txd_ready = 1'b1;
  logic [7:0]  txd_data;
  logic        brk_start = 1'b0;
  logic        bit_tick = 1'b0;
  logic        rxb_valid = 1'b0;
  logic [7:0]  rxb_data = '0;
  logic        rx_ready;
  logic        rx_rd = 1'b0;
  logic [7:0]  rx_data;
  logic        noresp_err;
  logic        overrun;
  logic [1:0]  err_clr = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int hdr_n = 0;
  logic [5:0] h_id;
  logic       h_tx;
  logic [3:0] h_len;
  logic [7:0] txq [0:15];
  int txn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_frame_ctrl u_lin_frame_ctrl (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_data,
    .hdr_valid, .hdr_ready, .hdr_id, .hdr_tx, .hdr_len,
    .txd_valid, .txd_ready, .txd_data,
    .brk_start, .bit_tick, .rxb_valid, .rxb_data,
    .rx_ready, .rx_rd, .rx_data, .noresp_err, .overrun, .err_clr
  );

  always @(negedge clk) begin
    #2;
    if (hdr_valid && hdr_ready) begin
      h_id = hdr_id; h_tx = hdr_tx; h_len = hdr_len; hdr_n++;
    end
    if (txd_valid && txd_ready && txn < 16) begin
      txq[txn] = txd_data; txn++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = d;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); bit_tick = 1'b1; end
    @(negedge clk); bit_tick = 1'b0; #3;
  endtask

  task automatic pulse_brk();
    @(negedge clk); brk_start = 1'b1;
    @(negedge clk); brk_start = 1'b0; #3;
  endtask

  task automatic rx_byte(input logic [7:0] d);
    @(negedge clk); rxb_valid = 1'b1; rxb_data = d;
    @(negedge clk); rxb_valid = 1'b0; #3;
  endtask

  task automatic pulse_clr(input logic [1:0] c);
    @(negedge clk); err_clr = c;
    @(negedge clk); err_clr = '0; #3;
  endtask

  task automatic read_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0; #3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  function automatic int rec_to(input int n);
    return ((10 * n + 45) * 14 + 9) / 10;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    #3;
    check("R1 cmd_ready", cmd_ready, 1);
    check("R1 hdr_valid", hdr_valid, 0);
    check("R1 txd_valid", txd_valid, 0);
    check("R1 rx_ready", rx_ready, 0);
    check("R1 noresp", noresp_err, 0);
    check("R1 overrun", overrun, 0);
    rst_n = 1'b1;
    idle(2);

    // transmit sweep: lengths 0..8, byte 3 nonzero and upper cmd bits set
    for (int len = 0; len <= 8; len++) begin
      int h0;
      h0 = hdr_n; txn = 0;
      send(16'hC300 | 16'(6'h15 ^ 6'(len)));
      send(16'h5A80 | 16'(len));
      send(16'hFF0F);
      for (int k = 0; k < len; k++) send(16'hA500 | 16'(len * 16 + k));
      idle(3);
      check("R2 hdr count", hdr_n - h0, 1);
      check("R2 hdr id", h_id, (6'h15 ^ 6'(len)));
      check("R2 hdr tx", h_tx, 1);
      check("R2 hdr len", h_len, len);
      check("R3 data count", txn, len);
      for (int k = 0; k < len; k++) check("R3 data byte", txq[k], (len * 16 + k) & 8'hFF);
      check("R3 back to byte1", cmd_ready, 1);
      pulse_brk();
      ticks(300);
      check("R7 tx no error", noresp_err, 0);
    end

    // receive timeout sweep with recommended timeout
    for (int len = 0; len <= 8; len++) begin
      t = rec_to(len);
      send(16'(len + 1));
      send(16'(len));
      send(16'(t >> 8));
      send(16'(t & 8'hFF));
      idle(2);
      check("R2 rx hdr tx", h_tx, 0);
      check("R2 rx hdr len", h_len, len);
      check("R11 wait break blocks", cmd_ready, 0);
      pulse_brk();
      ticks(t - 1);
      check("R4 no error before T", noresp_err, 0);
      check("R4 still busy before T", cmd_ready, 0);
      ticks(1);
      check("R4 error at T", noresp_err, 1);
      check("R5 abort idle", cmd_ready, 1);
      idle(4);
      check("R8 sticky", noresp_err, 1);
      pulse_clr(2'b01);
      check("R8 cleared", noresp_err, 0);
    end

    // timeout using upper bits from byte 3: T = 0x105
    send(16'h0001); send(16'h0002); send(16'h0001); send(16'h0005);
    idle(2);
    pulse_brk();
    ticks(260);
    check("R4 long T minus one", noresp_err, 0);
    ticks(1);
    check("R4 long T", noresp_err, 1);
    pulse_clr(2'b01);

    // receive response sweep: bytes arrive before the timeout
    for (int len = 0; len <= 8; len++) begin
      t = rec_to(len);
      send(16'h0003); send(16'(len));
      send(16'(t >> 8)); send(16'(t & 8'hFF));
      idle(2);
      pulse_brk();
      for (int k = 0; k <= len; k++) begin
        ticks(3);
        rx_byte(8'(8'h40 + len * 9 + k));
        check("R9 ready on byte", rx_ready, 1);
        check("R9 data shown", rx_data, (8'h40 + len * 9 + k) & 8'hFF);
        read_rx();
        check("R9 read clears", rx_ready, 0);
        check("R9 data gated", rx_data, 0);
      end
      check("R6 complete idle", cmd_ready, 1);
      ticks(300);
      check("R6 no error", noresp_err, 0);
    end

    // overrun
    rx_byte(8'h11);
    rx_byte(8'h22);
    check("R10 overrun set", overrun, 1);
    check("R10 new byte replaces", rx_data, 8'h22);
    pulse_clr(2'b10);
    check("R10 overrun cleared", overrun, 0);
    read_rx();

    // zero timeout receive frame
    send(16'h0004); send(16'h0001); send(16'h0000); send(16'h0000);
    idle(2);
    pulse_brk();
    ticks(400);
    check("R12 no error", noresp_err, 0);
    check("R12 still waiting", cmd_ready, 0);
    rx_byte(8'h01); rx_byte(8'h02);
    check("R12 ends on bytes", cmd_ready, 1);
    read_rx();
    pulse_clr(2'b10);

    // back-pressure on header and payload
    hdr_ready = 1'b0; txn = 0;
    send(16'h0009); send(16'h0082); send(16'h0000);
    idle(3);
    check("R11 hdr held", hdr_valid, 1);
    check("R11 cmd blocked by hdr", cmd_ready, 0);
    @(negedge clk); hdr_ready = 1'b1; txd_ready = 1'b0;
    idle(1);
    send(16'h0077);
    idle(1);
    check("R11 txd valid", txd_valid, 1);
    check("R11 cmd blocked by txd", cmd_ready, 0);
    idle(3);
    check("R11 txd stable", txd_data, 8'h77);
    @(negedge clk); txd_ready = 1'b1;
    send(16'h0088);
    idle(3);
    check("R11 bytes delivered", txn, 2);
    check("R11 order", txq[1], 8'h88);
    check("R3 idle after stall", cmd_ready, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule